// File: doc/BRIEF.md
# Configurable Logic Input Conditioner

This block conditions four digital status inputs for a supervisory controller. Such inputs are reset lines, power-good flags, fault flags and manual switches. Each channel first brings its raw input into the clock domain through two flip-flops. It can then invert the input and suppress changes that do not last for a programmable filter time. The conditioned signal is then either passed on as a level or, in edge mode, a rising transition is turned into a positive pulse of programmable width. The four results go to downstream gating logic.

Each channel is set up through its own 8-bit configuration register, written and read through a plain address/data port. All filter and pulse timers count a one-cycle tick. The tick fires once per microsecond and is derived from the system clock by a parameterized divider.

Top module: `lic_bank`

## Requirements
- R1: The configuration registers occupy addresses 0x98 to 0x9B. Address 0x9B controls channel 1 (`cond_out[0]`), 0x9A controls channel 2, 0x99 controls channel 3, and 0x98 controls channel 4 (`cond_out[3]`). Reads of any other address return 0x00.
- R2: After reset every configuration register reads 0x00 and every output is low while the inputs are low.
- R3: Bit 7 of a configuration register ignores writes and always reads 0. Bits 6..0 read back as last written.
- R4: Bit 6 set inverts the channel's input before filtering.
- R5: Bits 2..0 select the filter time. Codes 0..7 give 0, 5, 10, 20, 30, 50, 75 and 100 µs. For a nonzero code, the conditioned level changes only after the input has held its new value for that time. The change appears between (F-1) and F microseconds plus the synchronizer delay.
- R6: An input excursion that lasts less than the filter time has no effect on the output.
- R7: With filter code 0 in level mode, the output follows a raw input change after exactly 3 clock cycles.
- R8: With bit 5 clear (level mode), the output is the filtered, optionally inverted level.
- R9: With bit 5 set (edge mode), a rising edge of the filtered signal starts a high pulse. With filter code 0, that pulse appears 4 cycles after the raw change. A falling edge starts no pulse.
- R10: Bits 4..3 select the pulse width. Codes 0..3 give 10, 100, 1,000 and 10,000 µs, within one tick.
- R11: A rising edge that arrives while a pulse is active restarts the pulse timer.
- R12: A write to a channel's configuration register ends any pulse in progress on that channel.
- R13: The microsecond tick fires once every `CLK_PER_US` clock cycles, and all timers advance only on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| raw_in | input | NUM_CH | Raw asynchronous inputs, bit 0 is channel 1 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| cond_out | output | NUM_CH | Conditioned outputs, bit 0 is channel 1 |

## Verification
A register write takes effect at the next clock edge. With filter code 0, a raw change reaches a level output after 3 cycles and starts a pulse after 4 cycles. Both delays are checked as exact cycle counts. Filter latency and pulse width depend on where the free-running tick falls, so the bench measures them in cycles and accepts the one-tick window given in R5 and R10. Glitches are held one tick shorter than the filter time, and the output is then watched for a full filter time plus margin. Every sample is taken on the falling clock edge, after all registers have settled.

// File: rtl/lic_pkg.sv
package lic_pkg;

  localparam int FILT_CNT_W  = 7;
  localparam int PULSE_CNT_W = 14;

  typedef struct packed {
    logic       rsvd;
    logic       invert;
    logic       edge_mode;
    logic [1:0] pulse_sel;
    logic [2:0] filt_sel;
  } chan_cfg_t;

  // Filter hold time in microseconds for a 3-bit code.
  function automatic logic [FILT_CNT_W-1:0] filt_limit_us(input logic [2:0] sel);
    logic [FILT_CNT_W-1:0] v;
    case (sel)
      3'd0:    v = 7'd0;
      3'd1:    v = 7'd5;
      3'd2:    v = 7'd10;
      3'd3:    v = 7'd20;
      3'd4:    v = 7'd30;
      3'd5:    v = 7'd50;
      3'd6:    v = 7'd75;
      default: v = 7'd100;
    endcase
    return v;
  endfunction

  // Pulse width in microseconds: ten to the power (code + 1).
  function automatic logic [PULSE_CNT_W-1:0] pulse_limit_us(input logic [1:0] sel);
    logic [PULSE_CNT_W-1:0] v;
    v = 14'd10;
    for (int k = 0; k < 3; k++)
      if (k < int'(sel)) v = v * 14'd10;
    return v;
  endfunction

endpackage

// File: rtl/lic_tick_gen.sv
module lic_tick_gen #(
  parameter int CYCLES_PER_TICK = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_TICK - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (div_q == LAST)  div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);

  generate
    if (CYCLES_PER_TICK > 1) begin : g_spacing
      // R13: ticks are isolated single-cycle strobes
      a_r13_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/lic_cfg_regs.sv
module lic_cfg_regs
  import lic_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h98
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wr_data,
  output logic [7:0]              rd_data,
  output chan_cfg_t [NUM_CH-1:0]  cfg_o,
  output logic [NUM_CH-1:0]       wr_hit
);

  // Channel 1 sits at the highest address, the last channel at the base.
  function automatic logic [ADDR_W-1:0] chan_addr(input int idx);
    return ADDR_W'(BASE_ADDR + NUM_CH - 1 - idx);
  endfunction

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
      logic [6:0] bits_q;
      assign wr_hit[i] = wr_en && (addr == chan_addr(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bits_q <= '0;
        else if (wr_hit[i]) bits_q <= wr_data[6:0];
      end

      assign cfg_o[i] = chan_cfg_t'({1'b0, bits_q});

      // R3: written low bits land, top bit stays clear
      a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[i] |=> (cfg_o[i] == chan_cfg_t'({1'b0, $past(wr_data[6:0])})));
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == chan_addr(i)) rd_data = cfg_o[i];
  end

  // R1: at most one register decodes a write
  a_r1_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: rtl/lic_channel.sv
module lic_channel
  import lic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      raw_in,
  input  chan_cfg_t cfg_i,
  input  logic      cfg_wr,
  output logic      filt_level,
  output logic      edge_fire,
  output logic      cond_out
);

  logic meta_q, sync_q;
  logic cond_in;
  logic filt_q, filt_d;
  logic [FILT_CNT_W-1:0]  fcnt_q;
  logic [FILT_CNT_W-1:0]  filt_lim;
  logic pulse_q;
  logic [PULSE_CNT_W-1:0] pcnt_q;
  logic [PULSE_CNT_W-1:0] pulse_lim;

  // two-stage synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
    end
  end

  assign cond_in  = sync_q ^ cfg_i.invert;
  assign filt_lim = filt_limit_us(cfg_i.filt_sel);

  // glitch filter: level moves after a stable run of filt_lim ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      fcnt_q <= '0;
    end else if (cond_in == filt_q) begin
      fcnt_q <= '0;
    end else if (filt_lim == '0) begin
      filt_q <= cond_in;
      fcnt_q <= '0;
    end else if (tick) begin
      if (fcnt_q + 1'b1 >= filt_lim) begin
        filt_q <= cond_in;
        fcnt_q <= '0;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_d <= 1'b0;
    else        filt_d <= filt_q;
  end

  assign filt_level = filt_q;
  assign edge_fire  = filt_q & ~filt_d;
  assign pulse_lim  = pulse_limit_us(cfg_i.pulse_sel);

  // pulse stretcher, restarted by every new rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      pcnt_q  <= '0;
    end else if (cfg_wr) begin
      pulse_q <= 1'b0;
      pcnt_q  <= '0;
    end else if (cfg_i.edge_mode && edge_fire) begin
      pulse_q <= 1'b1;
      pcnt_q  <= '0;
    end else if (pulse_q && tick) begin
      if (pcnt_q + 1'b1 >= pulse_lim) begin
        pulse_q <= 1'b0;
        pcnt_q  <= '0;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign cond_out = cfg_i.edge_mode ? pulse_q : filt_q;

  // R5: a nonzero filter only moves its level on a tick
  a_r5_filter_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lim != '0 && !tick) |=> $stable(filt_q));

  // R9: a pulse starts only from a detected edge in edge mode
  a_r9_pulse_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(edge_fire && cfg_i.edge_mode));

  // R10: a pulse ends only on a tick or a configuration write
  a_r10_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_q) |-> $past(tick || cfg_wr));

  // R10: the pulse counter stays below its limit
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (pcnt_q < pulse_lim));

  // R12: a configuration write leaves no pulse behind
  a_r12_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !pulse_q);

  // R3: the reserved bit never reaches a channel
  a_r3_rsvd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.rsvd);

endmodule

// File: rtl/lic_bank.sv
module lic_bank
  import lic_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CLK_PER_US = 125,
  parameter int BASE_ADDR  = 'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raw_in,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [NUM_CH-1:0] cond_out
);

  logic                   us_tick;
  chan_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]      cfg_wr;
  logic [NUM_CH-1:0]      filt_level;
  logic [NUM_CH-1:0]      edge_fire;

  lic_tick_gen #(.CYCLES_PER_TICK(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (us_tick)
  );

  lic_cfg_regs #(.NUM_CH(NUM_CH), .ADDR_W(8), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .addr   (reg_addr),
    .wr_data(reg_wdata),
    .rd_data(reg_rdata),
    .cfg_o  (cfg),
    .wr_hit (cfg_wr)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      lic_channel u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (us_tick),
        .raw_in    (raw_in[i]),
        .cfg_i     (cfg[i]),
        .cfg_wr    (cfg_wr[i]),
        .filt_level(filt_level[i]),
        .edge_fire (edge_fire[i]),
        .cond_out  (cond_out[i])
      );

      // R8: in level mode an output moves only when its filtered level moves
      a_r8_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[i].edge_mode && $stable(cfg[i]) && $stable(filt_level[i])) |-> $stable(cond_out[i]));
    end
  endgenerate

endmodule

// File: tb/lic_bank_test.sv
`timescale 1ns/1ps
module lic_bank_test;
  localparam int CPU = 2;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] raw_in = '0;
  logic           reg_wr_en = 1'b0;
  logic [7:0]     reg_addr = 8'h00;
  logic [7:0]     reg_wdata = 8'h00;
  logic [7:0]     reg_rdata;
  logic [NCH-1:0] cond_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lic_bank #(.NUM_CH(NCH), .CLK_PER_US(CPU), .BASE_ADDR('h98)) uut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cond_out(cond_out)
  );

  function automatic int filt_us(input int c);
    int t[8] = '{0, 5, 10, 20, 30, 50, 75, 100};
    return t[c];
  endfunction

  function automatic int pulse_us(input int c);
    int v = 10;
    for (int k = 0; k < c; k++) v = v * 10;
    return v;
  endfunction

  function automatic logic [7:0] ch_addr(input int ch);
    return 8'h9B - 8'(ch);
  endfunction

  task automatic chk(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raw driven on a falling edge; returns rising edges until the output shows v
  task automatic latency(input int ch, input logic v, input int maxc, output int n);
    n = 0;
    while (n <= maxc) begin
      @(negedge clk);
      n++;
      if (cond_out[ch] == v) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    bit bad;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);

    // R2: reset state
    for (int i = 0; i < NCH; i++) begin
      rd(ch_addr(i), d);
      chk("R2 reset register", int'(d), 0, 0);
    end
    chk("R2 reset outputs", int'(cond_out), 0, 0);

    // R3: reserved bit
    wr(8'h9A, 8'hFF);
    rd(8'h9A, d);
    chk("R3 reserved bit reads 0", int'(d), 'h7F, 'h7F);
    wr(8'h9A, 8'h80);
    rd(8'h9A, d);
    chk("R3 write to bit 7 only", int'(d), 0, 0);

    // R1: address map and readback
    for (int i = 0; i < NCH; i++) wr(ch_addr(i), 8'h10 + 8'(i));
    for (int i = 0; i < NCH; i++) begin
      rd(ch_addr(i), d);
      chk("R1 readback", int'(d), 'h10 + i, 'h10 + i);
    end
    rd(8'h97, d);
    chk("R1 below map", int'(d), 0, 0);
    rd(8'h9C, d);
    chk("R1 above map", int'(d), 0, 0);
    for (int i = 0; i < NCH; i++) wr(ch_addr(i), 8'h00);
    wait_cyc(10);

    // R1/R4: inversion through the mapped addresses
    wr(8'h9B, 8'h40);
    wait_cyc(5);
    chk("R1 R4 channel 1 inverted", int'(cond_out), 1, 1);
    wr(8'h98, 8'h40);
    wait_cyc(5);
    chk("R1 R4 channel 4 inverted", int'(cond_out), 9, 9);
    raw_in[3] = 1'b1;
    wait_cyc(5);
    chk("R4 inverted high input", int'(cond_out), 1, 1);
    raw_in[3] = 1'b0;
    wr(8'h9B, 8'h00);
    wr(8'h98, 8'h00);
    wait_cyc(5);
    chk("R4 inversion removed", int'(cond_out), 0, 0);

    // R5 R6 R7 R8 R13: filter sweep, level mode, every channel and code
    for (int ch = 0; ch < NCH; ch++) begin
      for (int c = 0; c < 8; c++) begin
        int f;
        f = filt_us(c);
        wr(ch_addr(ch), 8'(c));
        wait_cyc(10);
        raw_in[ch] = 1'b1;
        latency(ch, 1'b1, f * CPU + 20, n);
        if (c == 0) chk("R7 unfiltered rise latency", n, 3, 3);
        else        chk("R5 R13 filtered rise latency", n, (f - 1) * CPU + 2, f * CPU + 3);
        chk("R8 other channels quiet", int'(cond_out & ~(4'b1 << ch)), 0, 0);
        raw_in[ch] = 1'b0;
        latency(ch, 1'b0, f * CPU + 20, n);
        if (c == 0) chk("R7 unfiltered fall latency", n, 3, 3);
        else        chk("R5 R13 filtered fall latency", n, (f - 1) * CPU + 2, f * CPU + 3);
        if (c != 0) begin
          wait_cyc(5);
          raw_in[ch] = 1'b1;
          wait_cyc((f - 1) * CPU);
          raw_in[ch] = 1'b0;
          bad = 0;
          repeat (f * CPU + 10) begin
            @(negedge clk);
            if (cond_out[ch]) bad = 1;
          end
          chk("R6 short glitch ignored", int'(bad), 0, 0);
        end
      end
      wr(ch_addr(ch), 8'h00);
    end

    // R9 R10: edge mode pulse widths on channel 1
    for (int p = 0; p < 4; p++) begin
      int l;
      l = pulse_us(p);
      wr(8'h9B, 8'h20 | 8'(p << 3));
      wait_cyc(10);
      raw_in[0] = 1'b1;
      latency(0, 1'b1, 10, n);
      chk("R9 pulse start latency", n, 4, 4);
      n = 1;
      while (cond_out[0] && n < l * CPU + 20) begin
        @(negedge clk);
        if (cond_out[0]) n++;
      end
      chk("R10 R13 pulse width", n, (l - 1) * CPU + 1, l * CPU);
      raw_in[0] = 1'b0;
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (cond_out[0]) bad = 1;
      end
      chk("R9 falling edge makes no pulse", int'(bad), 0, 0);
    end

    // R9: pulse on channel 4 as well
    wr(8'h98, 8'h20);
    wait_cyc(5);
    raw_in[3] = 1'b1;
    latency(3, 1'b1, 10, n);
    chk("R9 channel 4 pulse start", n, 4, 4);
    raw_in[3] = 1'b0;
    wait_cyc(40);
    wr(8'h98, 8'h00);

    // R11: restart during an active pulse (100 us)
    wr(8'h9B, 8'h28);
    wait_cyc(10);
    raw_in[0] = 1'b1;
    wait_cyc(100);
    raw_in[0] = 1'b0;
    wait_cyc(10);
    raw_in[0] = 1'b1;
    bad = 0;
    n = 0;
    while (n < 300) begin
      @(negedge clk);
      n++;
      if (!cond_out[0]) break;
    end
    chk("R11 restarted pulse end", n, 99 * CPU + 5, 100 * CPU + 4);
    raw_in[0] = 1'b0;
    wait_cyc(10);

    // R12: configuration write ends a pulse
    wr(8'h9B, 8'h38);
    wait_cyc(10);
    raw_in[0] = 1'b1;
    wait_cyc(50);
    chk("R12 pulse active before write", int'(cond_out[0]), 1, 1);
    wr(8'h9B, 8'h38);
    chk("R12 pulse cleared by write", int'(cond_out[0]), 0, 0);
    wait_cyc(50);
    chk("R12 no retrigger on steady input", int'(cond_out[0]), 0, 0);
    raw_in[0] = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule